// File: doc/BRIEF.md
# Write-Protected Option Register with External Interrupt Recognition

This block holds an 8-bit system option register and turns a shared, active-low external interrupt pin into a maskable interrupt request for the CPU. When the chip runs in a normal mode, software gets a single chance to program the option register. That chance exists only during a fixed count of clock cycles after reset. Once the first write is accepted or the count runs out, the register is frozen until the next reset. When the chip runs in a special mode, the register can be written at any time and as often as needed.

Bit 5 of the option register sets how the interrupt pin is recognized. When the bit is 0, a low level on the pin is recognized. When it is 1, a high-to-low transition is recognized. The pin first passes through a two-flop synchronizer. A recognized event sets a pending flag that software can read. While the flag is set and the CPU's global interrupt mask is clear, the request output stays asserted.

Software reaches the block through a one-bit-address register bus. Address 0 holds the option register. Address 1 holds the status register, whose bit 0 is the pending flag. In edge mode, writing a 1 to that bit clears the flag.

Top module: `cfg_irq_unit`

## Requirements
- R1: When reset is released, reading address 0 returns 0x10, the status read at address 1 returns 0x00, and irqReq is 0.
- R2: In normal mode (specialMode=0), the first write to address 0 is accepted if it lands on one of clock edges 0 through 63 after reset release, counting from 0. Edge 0 is the first rising edge with rstN high. The written value can be read back at the next read.
- R3: In normal mode, a write to address 0 on edge 64 or on any later edge is ignored, and the register keeps its value.
- R4: In normal mode, once one write has been accepted, every later write to address 0 is ignored, including writes that fall inside the 64-edge window.
- R5: In special mode (specialMode=1), every write to address 0 is accepted, at any cycle, any number of times.
- R6: Reads are combinational and always return the current contents, whatever the state of the lock. Address 0 returns the option register. Address 1 returns 7 zero bits above the pending flag in bit 0.
- R7: With option bit 5 = 0 (level mode), the pending flag is the inverse of the pin, delayed by three clock edges. A write of 1 to status bit 0 does not clear the flag while the pin stays low.
- R8: With option bit 5 = 1 (edge mode), a high-to-low pin transition sets the pending flag three edges later. The flag stays set after the pin returns high. A pin held low does not set the flag again once it has been cleared.
- R9: In edge mode, a write to address 1 with bit 0 = 1 clears the pending flag on that edge. A write with bit 0 = 0 leaves the flag unchanged.
- R10: irqReq is 1 exactly when the pending flag is 1 and iMask is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| specialMode | input | 1 | 1 = special mode, which removes the write lock |
| regAddr | input | 1 | Register select: 0 = option register, 1 = status register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr |
| irqPinN | input | 1 | Raw external interrupt pin, active low |
| iMask | input | 1 | CPU global interrupt mask |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest cases to reach are the edges of the write window: the last accepted edge (63) and the first locked edge (64). The block gives no indication of where it is in its count. The stimulus therefore sweeps the write position from edge 0 through edge 69, with a fresh reset before each position. It then reads the register and expects the written value only for positions below 64. Interrupt checks run in special mode, so the recognition mode can be changed freely. Each pin change is sampled exactly three edges later, which exercises the synchronizer latency in both recognition modes.

// File: rtl/cfg_irq_pkg.sv
package cfg_irq_pkg;
  localparam logic OPT_ADDR  = 1'b0;
  localparam logic STAT_ADDR = 1'b1;

  typedef struct packed {
    logic optWr;
    logic pendSet;
    logic pendClr;
  } ctlStrobes_t;
endpackage

// File: rtl/cfg_irq_ctrl.sv
module cfg_irq_ctrl
  import cfg_irq_pkg::*;
#(
  parameter int WIN_CYCLES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        specialMode,
  input  logic        regAddr,
  input  logic        wrEn,
  input  logic        clrBit,
  input  logic        irqPinN,
  input  logic        edgeMode,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0]       cycleCnt;
  logic                   written;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSync;
  logic                   pinSync;
  logic                   windowOpen;
  logic                   fallSeen;
  logic                   clrWrite;
  logic                   optWrite;

  // window counter, saturating at the window length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycleCnt <= '0;
    else if (cycleCnt != WIN_END) cycleCnt <= cycleCnt + 1'b1;
  end

  assign windowOpen = (cycleCnt < WIN_END) && !written;
  assign optWrite   = wrEn && (regAddr == OPT_ADDR) && (specialMode || windowOpen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) written <= 1'b0;
    else if (optWrite && !specialMode) written <= 1'b1;
  end

  // pin synchronizer, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      prevSync <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], irqPinN};
      prevSync <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinSync  = syncQ[SYNC_STAGES-1];
  assign fallSeen = prevSync && !pinSync;
  assign clrWrite = wrEn && (regAddr == STAT_ADDR) && clrBit;

  always_comb begin
    strobes.optWr = optWrite;
    if (edgeMode) begin
      strobes.pendSet = fallSeen;
      strobes.pendClr = clrWrite;
    end else begin
      strobes.pendSet = !pinSync;
      strobes.pendClr = pinSync;
    end
  end
endmodule

// File: rtl/cfg_irq_dpath.sv
module cfg_irq_dpath
  import cfg_irq_pkg::*;
#(
  parameter int             REG_W     = 8,
  parameter logic [REG_W-1:0] RESET_VAL = 8'h10,
  parameter int             EDGE_BIT  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             regAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             iMask,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] optQ,
  output logic             pendQ,
  output logic             edgeMode,
  output logic             irqReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) optQ <= RESET_VAL;
    else if (strobes.optWr) optQ <= wrData;
  end

  // set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else if (strobes.pendSet) pendQ <= 1'b1;
    else if (strobes.pendClr) pendQ <= 1'b0;
  end

  assign edgeMode = optQ[EDGE_BIT];
  assign irqReq   = pendQ && !iMask;
  assign rdData   = (regAddr == OPT_ADDR) ? optQ : {{(REG_W-1){1'b0}}, pendQ};
endmodule

// File: rtl/cfg_irq_unit.sv
module cfg_irq_unit
  import cfg_irq_pkg::*;
#(
  parameter int WIN_CYCLES  = 64,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8,
  parameter int EDGE_BIT    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             specialMode,
  input  logic             regAddr,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             irqPinN,
  input  logic             iMask,
  output logic             irqReq
);
  ctlStrobes_t      strobes;
  logic             edgeMode;
  logic [REG_W-1:0] optCur;
  logic             pendCur;

  cfg_irq_ctrl #(.WIN_CYCLES(WIN_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .regAddr(regAddr),
    .wrEn(wrEn), .clrBit(wrData[0]), .irqPinN(irqPinN), .edgeMode(edgeMode),
    .strobes(strobes)
  );

  cfg_irq_dpath #(.REG_W(REG_W), .RESET_VAL(REG_W'(8'h10)), .EDGE_BIT(EDGE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr), .wrData(wrData),
    .iMask(iMask), .rdData(rdData), .optQ(optCur), .pendQ(pendCur),
    .edgeMode(edgeMode), .irqReq(irqReq)
  );
endmodule

// File: rtl/cfg_irq_unit_chk.sv
module cfg_irq_unit_chk #(
  parameter int WIN_CYCLES = 64,
  parameter int REG_W      = 8,
  parameter int EDGE_BIT   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             specialMode,
  input logic             regAddr,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic             irqPinN,
  input logic             iMask,
  input logic             irqReq,
  input logic [REG_W-1:0] optCur,
  input logic             pendCur
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  logic [CW-1:0] chkCnt;
  logic          chkWrote;
  logic          normWr;

  assign normWr = wrEn && (regAddr == 1'b0) && !specialMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt   <= '0;
      chkWrote <= 1'b0;
    end else begin
      if (chkCnt != CW'(WIN_CYCLES)) chkCnt <= chkCnt + 1'b1;
      if (normWr && chkCnt < CW'(WIN_CYCLES)) chkWrote <= 1'b1;
    end
  end

  // R2
  window_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && chkCnt < CW'(WIN_CYCLES) && !chkWrote) |=> optCur == $past(wrData));
  // R3
  late_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && chkCnt >= CW'(WIN_CYCLES)) |=> $stable(optCur));
  // R4
  second_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && chkWrote) |=> $stable(optCur));
  // R5
  special_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 1'b0 && specialMode) |=> optCur == $past(wrData));
  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt >= CW'(4) && !$past(optCur[EDGE_BIT])) |-> pendCur == !$past(irqPinN, 3));
  // R10
  masked_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (pendCur && !iMask));
endmodule

bind cfg_irq_unit cfg_irq_unit_chk #(.WIN_CYCLES(WIN_CYCLES), .REG_W(REG_W), .EDGE_BIT(EDGE_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .specialMode(specialMode), .regAddr(regAddr), .wrEn(wrEn),
  .wrData(wrData), .irqPinN(irqPinN), .iMask(iMask), .irqReq(irqReq),
  .optCur(optCur), .pendCur(pendCur)
);

// File: tb/sim_cfg_irq_unit.sv
`timescale 1ns/1ps
module sim_cfg_irq_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       specialMode = 1'b0;
  logic       regAddr = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqPinN = 1'b1;
  logic       iMask = 1'b0;
  logic       irqReq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_irq_unit u0 (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqPinN(irqPinN),
    .iMask(iMask), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // reset; returns at the negedge preceding edge 0
  task automatic doReset(input logic special);
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; irqPinN = 1'b1; iMask = 1'b0;
    specialMode = special;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive a write for the coming edge, end on the following negedge
  task automatic writeReg(input logic addr, input logic [7:0] data);
    regAddr = addr; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic addr, output logic [7:0] data);
    regAddr = addr;
    #1 data = rdData;
  endtask

  initial begin
    logic [7:0] rd;
    // R1 reset state
    doReset(1'b0);
    readReg(1'b0, rd); check("R1", rd, 8'h10);
    readReg(1'b1, rd); check("R1", rd, 8'h00);
    check("R1", {7'b0, irqReq}, 8'h00);

    // R2/R3 sweep of write position over edges 0..69
    for (int k = 0; k < 70; k++) begin
      logic [7:0] v;
      v = 8'((k * 37 + 5) & 8'hEF) | 8'h01;
      doReset(1'b0);
      repeat (k) @(negedge clk);
      writeReg(1'b0, v);
      readReg(1'b0, rd);
      if (k < 64) check("R2", rd, v);
      else        check("R3", rd, 8'h10);
    end

    // R4 second write inside the window ignored
    doReset(1'b0);
    repeat (3) @(negedge clk);
    writeReg(1'b0, 8'hA5);
    repeat (4) @(negedge clk);
    writeReg(1'b0, 8'h5A);
    readReg(1'b0, rd); check("R4", rd, 8'hA5);
    // R6 read after lock still returns contents
    repeat (80) @(negedge clk);
    readReg(1'b0, rd); check("R6", rd, 8'hA5);

    // R5 special mode writes at any time
    doReset(1'b1);
    repeat (100) @(negedge clk);
    writeReg(1'b0, 8'h3C);
    readReg(1'b0, rd); check("R5", rd, 8'h3C);
    repeat (50) @(negedge clk);
    writeReg(1'b0, 8'hC3);
    readReg(1'b0, rd); check("R5", rd, 8'hC3);

    // R7 level mode
    writeReg(1'b0, 8'h00);
    irqPinN = 1'b0;
    repeat (2) @(negedge clk);
    readReg(1'b1, rd); check("R7 latency", rd, 8'h00);
    @(negedge clk);
    readReg(1'b1, rd); check("R7", rd, 8'h01);
    writeReg(1'b1, 8'h01);
    readReg(1'b1, rd); check("R7 no clear while low", rd, 8'h01);
    // R10 all mask and pending combinations
    for (int m = 0; m < 2; m++) begin
      iMask = m[0];
      #1 check("R10", {7'b0, irqReq}, {7'b0, !m[0]});
    end
    iMask = 1'b0;
    irqPinN = 1'b1;
    repeat (3) @(negedge clk);
    readReg(1'b1, rd); check("R7 release", rd, 8'h00);
    for (int m = 0; m < 2; m++) begin
      iMask = m[0];
      #1 check("R10", {7'b0, irqReq}, 8'h00);
    end
    iMask = 1'b0;

    // R8 edge mode
    writeReg(1'b0, 8'h20);
    readReg(1'b0, rd); check("R6", rd, 8'h20);
    repeat (3) @(negedge clk);
    irqPinN = 1'b0;
    repeat (3) @(negedge clk);
    readReg(1'b1, rd); check("R8", rd, 8'h01);
    irqPinN = 1'b1;
    repeat (4) @(negedge clk);
    readReg(1'b1, rd); check("R8 held", rd, 8'h01);
    // R9 clear with bit 0 = 0 does nothing, bit 0 = 1 clears
    writeReg(1'b1, 8'hFE);
    readReg(1'b1, rd); check("R9 no clear", rd, 8'h01);
    writeReg(1'b1, 8'h01);
    readReg(1'b1, rd); check("R9 clear", rd, 8'h00);
    // R8 pin held low after clear does not re-set
    irqPinN = 1'b0;
    repeat (3) @(negedge clk);
    readReg(1'b1, rd); check("R8 second edge", rd, 8'h01);
    writeReg(1'b1, 8'h01);
    repeat (5) @(negedge clk);
    readReg(1'b1, rd); check("R8 low no reset", rd, 8'h00);
    check("R10", {7'b0, irqReq}, 8'h00);
    irqPinN = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nErrors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule